// File: doc/BRIEF.md
# Video Stream Capture Filter

The block sits between an 8-bit digital video input carrying embedded timing references and a memory-write path. It watches the byte stream for the four-byte timing reference (three fixed bytes, then a status byte that carries the field, vertical-blanking and line-edge flags). It locks to the start of field 1 and then forwards only the part of each field that the selected capture mode asks for, as a valid/data stream.

Three capture modes are offered. The first keeps only active picture samples and drops every blanking byte and every timing reference. The second keeps only the vertical blanking lines. The third keeps every byte after lock, timing references included. In the first mode a programmable limit caps how many active lines are kept per frame, and a one-cycle frame-done pulse marks both the end of the last allowed line and each new field-1 start. An enable input drops lock and clears the line count.

Top module: `vcap_filter`

## Requirements
- R1: A timing reference is the byte sequence 0xFF, 0x00, 0x00 followed by a status byte. Status bit 6 is the field flag F, bit 5 the vertical-blanking flag V, and bit 4 the line-edge flag H (0 = start of active line, 1 = end of active line). A sequence 0xFF, 0x00 followed by anything other than 0x00 is ordinary data.
- R2: After reset or enable, nothing is forwarded until lock. Lock happens at the first reference with F=0 that comes after a reference with F=1, or that comes before any other reference. The first byte eligible for forwarding is the one after that reference's status byte.
- R3: With mode = 0 (active only), the block forwards only the bytes that follow a start-of-line reference with V=0, up to the next reference. All four reference bytes are dropped.
- R4: In mode 0, each start-of-line reference with V=0 counts one line, while the count is below the limit input. Lines beyond the limit are not forwarded. The count restarts at every field-1 start. A limit of 0 forwards no active bytes.
- R5: With mode = 1 (vertical blanking only), the block forwards the non-reference bytes that follow a reference with V=1, up to the next reference with V=0. Reference bytes are dropped.
- R6: With mode = 2 (entire field), the block forwards every byte after lock, including reference bytes and blanking data.
- R7: With mode = 3, nothing is forwarded.
- R8: A forwarded byte appears on outData with outValid high for one cycle. That cycle follows the clock edge that accepts the third valid input byte after it. Order is preserved. Cycles with inValid low neither accept nor emit a byte.
- R9: While enable is low, nothing is forwarded, including bytes already accepted. Lock and the line count are cleared, so after enable returns the block must lock again per R2.
- R10: frameDone is high for one cycle after the edge that accepts the status byte of a field-1 start reference. It also pulses after the edge that accepts the end-of-line status byte closing the limit-th counted line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High to run; low drops lock and clears the line count |
| mode | input | 2 | Capture mode: 0 active, 1 vertical blanking, 2 entire field, 3 none |
| lineLimit | input | LINE_W | Active lines kept per frame in mode 0 |
| inValid | input | 1 | Input byte strobe |
| inData | input | DATA_W | Input byte |
| outValid | output | 1 | Forwarded byte strobe |
| outData | output | DATA_W | Forwarded byte |
| frameDone | output | 1 | One-cycle frame event pulse |

## Verification
The bench goes after the end-of-line reference that falls inside kept active data. A filter without look-back would leak its three leading bytes into memory. It checks that a half-matched preamble inside picture data survives as data; a detector that matched loosely would cut the line short. Streams open partway through field 2 and are checked for lock. A lock on any F=0 reference, or an immediate lock, shows up as extra leading bytes. The line limit is run at 0, at 3 and above the line count, which catches a comparison off by one line or a count that never restarts at field 1. Enable is also dropped during active video, where a design that let the pipeline drain would emit stale bytes.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  typedef enum logic [1:0] {
    CAP_ACTIVE = 2'd0,
    CAP_VBLANK = 2'd1,
    CAP_FIELD  = 2'd2,
    CAP_NONE   = 2'd3
  } capMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic keepNew;   // tag the byte entering now as forwardable
    logic dropPre;   // strip timing reference bytes
    logic flush;     // clear every pending tag
  } dpCtrl_t;

  // decoded timing reference, valid with hit
  typedef struct packed {
    logic hit;
    logic fBit;
    logic vBit;
    logic hBit;
  } trsInfo_t;

  localparam int PRE_LEN = 3;   // fixed bytes before the status byte

endpackage

// File: rtl/vcap_datapath.sv
module vcap_datapath
  import vcap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  dpCtrl_t           ctl,
  output trsInfo_t          trs,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int HIST = PRE_LEN;
  localparam int OLD  = HIST - 1;
  localparam logic [DATA_W-1:0] ALL_ONE  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ALL_ZERO = '0;

  // slot 0 is the newest stored byte, slot OLD the one leaving next
  logic [HIST-1:0][DATA_W-1:0] histData;
  logic [HIST-1:0]             histKeep;
  logic [HIST-1:0]             keepNxt;
  logic                        preMatch;
  logic                        stripNow;

  always_comb begin
    preMatch = (histData[OLD] == ALL_ONE);
    for (int k = 0; k < OLD; k++) begin
      preMatch = preMatch && (histData[k] == ALL_ZERO);
    end
  end

  assign trs.hit  = inValid && preMatch;
  assign trs.fBit = inData[DATA_W-2];
  assign trs.vBit = inData[DATA_W-3];
  assign trs.hBit = inData[DATA_W-4];

  assign stripNow = trs.hit && ctl.dropPre;

  generate
    for (genvar i = 0; i < HIST; i++) begin : gSlot
      if (i == 0) begin : gHead
        assign keepNxt[i] = ctl.keepNew && !stripNow;
      end else begin : gBody
        assign keepNxt[i] = histKeep[i-1] && !stripNow;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histData <= '0;
      histKeep <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= inValid && histKeep[OLD] && !ctl.flush && !stripNow;
      if (inValid) begin
        outData  <= histData[OLD];
        histData <= {histData[OLD-1:0], inData};
        histKeep <= keepNxt;
      end
      if (ctl.flush) begin
        histKeep <= '0;
      end
    end
  end

endmodule

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
  import vcap_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] lineLimit,
  input  trsInfo_t          trs,
  output dpCtrl_t           ctl,
  output logic              frameDone
);

  capMode_e          modeSel;
  logic              synced;
  logic              prevF;
  logic              vFlag;
  logic              capturing;
  logic [LINE_W-1:0] lineCount;

  logic              fStart;
  logic              syncNext;
  logic              startLine;
  logic              exhaust;
  logic [LINE_W-1:0] countBase;
  logic              gate;

  assign modeSel = capMode_e'(mode);

  always_comb begin
    fStart    = trs.hit && !trs.fBit && prevF;
    countBase = fStart ? '0 : lineCount;
    syncNext  = synced || fStart;
    startLine = syncNext && !trs.hBit && !trs.vBit && (countBase < lineLimit);
    exhaust   = trs.hit && synced && capturing && trs.hBit
                && (lineCount == lineLimit);
    unique case (modeSel)
      CAP_ACTIVE: gate = capturing;
      CAP_VBLANK: gate = synced && vFlag;
      CAP_FIELD:  gate = synced;
      default:    gate = 1'b0;
    endcase
  end

  assign ctl.keepNew = enable && gate;
  assign ctl.dropPre = (modeSel != CAP_FIELD);
  assign ctl.flush   = !enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      synced    <= 1'b0;
      prevF     <= 1'b1;
      vFlag     <= 1'b0;
      capturing <= 1'b0;
      lineCount <= '0;
      frameDone <= 1'b0;
    end else if (!enable) begin
      synced    <= 1'b0;
      prevF     <= 1'b1;
      vFlag     <= 1'b0;
      capturing <= 1'b0;
      lineCount <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= fStart || exhaust;
      if (trs.hit) begin
        prevF <= trs.fBit;
        if (syncNext) begin
          synced    <= 1'b1;
          vFlag     <= trs.vBit;
          capturing <= startLine;
          lineCount <= startLine ? countBase + LINE_W'(1) : countBase;
        end
      end
    end
  end

endmodule

// File: rtl/vcap_filter.sv
module vcap_filter
  import vcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] lineLimit,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              frameDone
);

  dpCtrl_t  ctl;
  trsInfo_t trs;

  vcap_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .lineLimit(lineLimit), .trs(trs), .ctl(ctl), .frameDone(frameDone)
  );

  vcap_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .ctl(ctl), .trs(trs), .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/vcap_checker.sv
module vcap_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic inValid,
  input logic outValid,
  input logic frameDone
);

  logic pastOk;
  logic doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastOk   <= 1'b0;
      doneSeen <= 1'b0;
    end else begin
      pastOk   <= 1'b1;
      doneSeen <= enable && (doneSeen || frameDone);
    end
  end

  // R8: an output byte only follows an accepted input byte
  a_r8_out_needs_in: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && outValid |-> $past(inValid));

  // R9: disabled cycle forwards nothing
  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(enable) |-> !outValid);

  // R2: lock (always marked by frameDone) precedes any forwarded byte
  a_r2_lock_first: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> doneSeen);

  // R10: pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R10: pulse follows an accepted byte while enabled
  a_r10_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && frameDone |-> ($past(inValid) && $past(enable)));

endmodule

bind vcap_filter vcap_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
  .outValid(outValid), .frameDone(frameDone)
);

// File: tb/sim_vcap_filter.sv
module sim_vcap_filter;

  localparam int DW = 8;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic [LW-1:0] lineLimit = '0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          frameDone;

  always #2 clk = ~clk;

  vcap_filter #(.DATA_W(DW), .LINE_W(LW)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .lineLimit(lineLimit), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData), .frameDone(frameDone)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] strm[$];
  bit         enQ[$];
  bit         gapQ[$];
  int         payCnt;
  int         gapEvery;

  logic [7:0] expOut[$];
  int         expDone[$];
  int         expFirst;
  logic [7:0] gotOut[$];
  int         gotDone[$];
  int         gotFirst;
  int         idleBad;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- stream construction ----------------
  function automatic void clearStream();
    strm.delete(); enQ.delete(); gapQ.delete();
    payCnt = 0;
  endfunction

  function automatic void pushB(input logic [7:0] b);
    strm.push_back(b);
    enQ.push_back(1'b1);
    gapQ.push_back(gapEvery != 0 && (strm.size() % gapEvery) == 0);
  endfunction

  function automatic void addTrs(input bit f, input bit v, input bit h);
    pushB(8'hFF); pushB(8'h00); pushB(8'h00);
    pushB(8'h80 | (8'(f) << 6) | (8'(v) << 5) | (8'(h) << 4));
  endfunction

  function automatic void addLine(input bit f, input bit v, input bit spike);
    addTrs(f, v, 1'b1);
    for (int k = 0; k < 4; k++) pushB((k % 2) ? 8'h10 : 8'h80);
    addTrs(f, v, 1'b0);
    for (int k = 0; k < 6; k++) begin
      pushB(8'(1 + (payCnt % 254)));
      payCnt++;
    end
    if (spike) begin
      pushB(8'hFF); pushB(8'h00); pushB(8'h5A);
    end
  endfunction

  function automatic void addField(input bit f, input int nv, input int na,
                                   input bit spikeLast);
    for (int k = 0; k < nv; k++) addLine(f, 1'b1, 1'b0);
    for (int k = 0; k < na; k++) addLine(f, 1'b0, spikeLast && (k == na - 1));
  endfunction

  function automatic void buildStd();
    clearStream();
    for (int k = 0; k < 5; k++) pushB(8'h33);
    addField(1'b1, 1, 2, 1'b0);     // tail of a field 2: must not lock
    addField(1'b0, 2, 4, 1'b0);     // field 1
    addField(1'b1, 2, 4, 1'b1);     // field 2, last line holds FF 00 5A
    addField(1'b0, 1, 1, 1'b0);     // next frame start
    for (int k = 0; k < 3; k++) pushB(8'h44);   // flush bytes
  endfunction

  // ---------------- reference model from the requirements ----------------
  function automatic void model(input int md, input int lim);
    bit synced = 0, prevF = 1, vF = 0, cap = 0;
    int cnt = 0;
    int n = strm.size();
    bit keep[];
    keep = new[n];
    expOut.delete(); expDone.delete(); expFirst = -1;
    for (int i = 0; i < n; i++) begin
      bit gate, det;
      if (!enQ[i]) begin
        synced = 0; prevF = 1; vF = 0; cap = 0; cnt = 0;
        keep[i] = 0;
        for (int k = 1; k <= 3; k++) if (i - k >= 0) keep[i-k] = 0;
        continue;
      end
      case (md)
        0: gate = cap;
        1: gate = synced && vF;
        2: gate = synced;
        default: gate = 0;
      endcase
      keep[i] = gate;
      det = (i >= 3) && strm[i-3] == 8'hFF && strm[i-2] == 8'h00 && strm[i-1] == 8'h00;
      if (det) begin
        bit f = strm[i][6], v = strm[i][5], h = strm[i][4];
        bit fs = !f && prevF;
        bit ex = synced && cap && h && (cnt == lim);
        int base;
        if (md != 2) for (int k = 0; k <= 3; k++) keep[i-k] = 0;
        if (fs || ex) expDone.push_back(i);
        prevF = f;
        base = fs ? 0 : cnt;
        if (synced || fs) begin
          bit sl = !h && !v && (base < lim);
          synced = 1; vF = v; cap = sl;
          cnt = sl ? base + 1 : base;
        end
      end
    end
    for (int j = 0; j < n - 3; j++) begin
      if (keep[j]) begin
        expOut.push_back(strm[j]);
        if (expFirst < 0) expFirst = j + 3;
      end
    end
  endfunction

  // ---------------- driver ----------------
  task automatic doReset();
    rstN = 1'b0; enable = 1'b1; inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid in reset", int'(outValid), 0);
    check(frameDone == 1'b0, "R10", "frameDone in reset", int'(frameDone), 0);
    rstN = 1'b1;
  endtask

  task automatic sample(input int idx);
    if (outValid) begin
      if (idx < 0) idleBad++;
      else begin
        gotOut.push_back(outData);
        if (gotFirst < 0) gotFirst = idx;
      end
    end
    if (frameDone) gotDone.push_back(idx);
  endtask

  task automatic runStream(input int md, input int lim);
    mode = 2'(md); lineLimit = LW'(lim);
    doReset();
    gotOut.delete(); gotDone.delete(); gotFirst = -1; idleBad = 0;
    for (int i = 0; i < strm.size(); i++) begin
      if (gapQ[i]) begin
        inValid = 1'b0;
        @(posedge clk); @(negedge clk);
        sample(-1);
      end
      inValid = 1'b1; inData = strm[i]; enable = enQ[i];
      @(posedge clk); @(negedge clk);
      sample(i);
    end
    inValid = 1'b0; enable = 1'b1;
    model(md, lim);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    check(gotOut.size() == expOut.size(), req, "forwarded count",
          gotOut.size(), expOut.size());
    for (int k = 0; k < gotOut.size() && k < expOut.size(); k++)
      if (bad < 0 && gotOut[k] != expOut[k]) bad = k;
    check(bad < 0, req, "first mismatching byte",
          (bad < 0) ? 0 : int'(gotOut[bad]), (bad < 0) ? 0 : int'(expOut[bad]));
    bad = (gotDone.size() == expDone.size()) ? -1 : 0;
    for (int k = 0; k < gotDone.size() && k < expDone.size(); k++)
      if (bad < 0 && gotDone[k] != expDone[k]) bad = k;
    check(bad < 0, {req, " R10"}, "frameDone byte index",
          (bad < 0 || bad >= gotDone.size()) ? gotDone.size() : gotDone[bad],
          (bad < 0 || bad >= expDone.size()) ? expDone.size() : expDone[bad]);
    check(idleBad == 0, "R8", "outValid on idle cycle", idleBad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic testActive();
    gapEvery = 0; buildStd();
    runStream(0, 100);
    compare("R1 R2 R3");
    check(gotOut.size() == 57, "R3", "active bytes incl FF 00 5A data", gotOut.size(), 57);
    check(gotDone.size() == 2, "R2", "field-1 starts seen", gotDone.size(), 2);
    check(gotFirst == expFirst, "R8", "first output latency", gotFirst, expFirst);
  endtask

  task automatic testLimit();
    gapEvery = 0; buildStd();
    runStream(0, 3);
    compare("R4");
    check(gotOut.size() == 24, "R4", "bytes with limit 3", gotOut.size(), 24);
    check(gotDone.size() == 3, "R10", "pulses with limit 3", gotDone.size(), 3);
    runStream(0, 0);
    check(gotOut.size() == 0, "R4", "bytes with limit 0", gotOut.size(), 0);
    check(gotDone.size() == 2, "R10", "pulses with limit 0", gotDone.size(), 2);
  endtask

  task automatic testVblank();
    gapEvery = 0; buildStd();
    runStream(1, 100);
    compare("R5");
    check(gotOut.size() == 50, "R5", "blanking bytes", gotOut.size(), 50);
  endtask

  task automatic testEntire();
    gapEvery = 5; buildStd();
    runStream(2, 100);
    compare("R6 R8");
    check(gotOut.size() > 0 && gotOut[0] == 8'h80, "R6", "first byte after lock",
          (gotOut.size() > 0) ? int'(gotOut[0]) : -1, 8'h80);
    gapEvery = 0;
  endtask

  task automatic testNone();
    gapEvery = 0; buildStd();
    runStream(3, 100);
    check(gotOut.size() == 0, "R7", "mode 3 forwards", gotOut.size(), 0);
  endtask

  task automatic testDisable();
    int a;
    gapEvery = 0; buildStd();
    a = strm.size() / 3;
    for (int k = a; k < a + 20; k++) enQ[k] = 1'b0;
    runStream(0, 100);
    compare("R9");
    check(gotOut.size() < 57, "R9", "bytes with enable dropped", gotOut.size(), 56);
  endtask

  initial begin
    gapEvery = 0;
    testActive();
    testLimit();
    testVblank();
    testEntire();
    testNone();
    testDisable();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule